// File: doc/BRIEF.md
# FIFO with Programmable Level Flags

A single-clock first-in first-out buffer of 9-bit words whose storage depth `DEPTH` is a power of two. Writes are accepted with `wen` and reads are requested with `ren`. The read timing mode is taken from `ft_mode` while master reset is high. After that it stays fixed until the next master reset. In standard mode a read request loads the next word into the output register `dout` on the following edge. In that mode `head_flag` means empty and `room_flag` means full. In fall-through mode the oldest word moves into `dout` without any request. The output register then counts as one extra storage slot, so up to `DEPTH+1` words can be held. In that mode `head_flag` means output-ready and `room_flag` means input-ready.

Three level flags are derived from the stored word count: almost-empty, almost-full and half-full. Two offsets set the almost-empty and almost-full thresholds. A small offset register block holds them. Master reset reloads their default values, and `ofs_wr` loads new values. A retransmit pulse `rt` moves reading back to memory location 0, so the words written since the last reset can be read again. Partial reset `prst` empties the buffer but keeps the timing mode and the offsets.

The read side is controlled by a three-state machine:
- `S_STD`: standard mode. It has no transitions.
- `S_FT_DRY`: fall-through mode with no word in the output register. It moves to `S_FT_HELD` when memory holds a word, and that word is loaded into `dout`.
- `S_FT_HELD`: fall-through mode with the head word valid in `dout`. It moves back to `S_FT_DRY` when a read takes the last word.

Partial reset and retransmit force `S_FT_HELD` to `S_FT_DRY`. Master reset enters `S_STD` or `S_FT_DRY` according to `ft_mode`.

Top module: `fifo_lvl_top`

## Requirements
- R1: In standard mode `room_flag` (full, 1 = full) is 1 exactly when the count equals DEPTH. With no reads after a reset it rises after the DEPTH-th write. A write while full is dropped: the stored data and the later read order are unchanged.
- R2: `almost_full` is 1 when the count is at least DEPTH−m in standard mode, or when the total held count is at least DEPTH+1−m in fall-through mode. Here m is the full offset.
- R3: `half_full` is 1 when the count is at least DEPTH/2+1 in standard mode, or when the total held count is at least DEPTH/2+2 in fall-through mode.
- R4: `almost_empty` is 1 while the count (the total held count in fall-through mode) is at or below the empty offset n.
- R5: In fall-through mode the first word written reaches `dout` without a read, and `head_flag` (output-ready, 1 = valid) rises one cycle after the write cycle. The head word stays in `dout` until it is read. Up to DEPTH+1 words are held. `room_flag` (input-ready, 1 = accepting) falls when the (DEPTH+1)-th word is stored, and further writes are dropped.
- R6: In standard mode a read of a non-empty FIFO puts the oldest word on `dout` at the next edge. `head_flag` (empty, 1 = empty) is 1 exactly when the count is 0. A read while empty leaves `dout` unchanged.
- R7: A read and a write in the same cycle on a FIFO that is neither empty nor full leave the count, and so every flag, unchanged.
- R8: The timing mode is captured only while `mrst` is high. Changes on `ft_mode` at any other time, including during a partial reset, have no effect.
- R9: A retransmit pulse makes the next word read come from location 0. The count becomes the number of words written since the last reset (at most DEPTH). In fall-through mode the word at location 0 reappears on `dout` one cycle after the pulse.
- R10: Partial reset empties the FIFO and clears `dout` to 0. It keeps the timing mode and the current offsets.
- R11: Master reset empties the FIFO, clears `dout` to 0 and reloads the default offsets. A cycle with `ofs_wr` high loads `ofs_empty_in` as n and `ofs_full_in` as m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| ft_mode | input | 1 | Mode select sampled during master reset (1 = fall-through) |
| wen | input | 1 | Write enable |
| ren | input | 1 | Read enable |
| rt | input | 1 | Retransmit pulse |
| din | input | 9 | Write data |
| ofs_wr | input | 1 | Load both offsets |
| ofs_empty_in | input | CW | New empty offset n |
| ofs_full_in | input | CW | New full offset m |
| dout | output | 9 | Output register |
| head_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| room_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| almost_empty | output | 1 | Count at or below n |
| almost_full | output | 1 | Count within m of capacity |
| half_full | output | 1 | Count past half of capacity |

CW = log2(DEPTH)+1.

## Verification
The bench builds the block with DEPTH = 8 and both default offsets set to 2. This small depth lets every fill level from empty to full be stepped through in both timing modes. At each level every flag is compared against thresholds the bench computes itself. The same setting makes the full capacity of DEPTH+1 words, wrap-around of the pointers and a retransmit after partial reads easy to reach. A reprogrammed offset pair (n = 4, m = 1) then shows the thresholds moving, surviving a partial reset and returning to the defaults after a master reset.

// File: rtl/fifo_lvl_pkg.sv
package fifo_lvl_pkg;
    typedef enum logic [1:0] {
        S_STD     = 2'd0,
        S_FT_DRY  = 2'd1,
        S_FT_HELD = 2'd2
    } rd_state_t;
endpackage

// File: rtl/fifo_lvl_store.sv
module fifo_lvl_store #(
    parameter int DW = 9,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int ENTRIES = 1 << AW;

    logic [DW-1:0] cells [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_lvl_ofs.sv
module fifo_lvl_ofs #(
    parameter int CW = 7,
    parameter int DEF_EMPTY_OFS = 4,
    parameter int DEF_FULL_OFS = 4
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          ld,
    input  logic [CW-1:0] empty_in,
    input  logic [CW-1:0] full_in,
    output logic [CW-1:0] empty_ofs,
    output logic [CW-1:0] full_ofs
);
    always_ff @(posedge clk) begin
        if (mrst) begin
            empty_ofs <= CW'(DEF_EMPTY_OFS);
            full_ofs  <= CW'(DEF_FULL_OFS);
        end else if (ld) begin
            empty_ofs <= empty_in;
            full_ofs  <= full_in;
        end
    end
endmodule

// File: rtl/fifo_lvl_flags.sv
module fifo_lvl_flags #(
    parameter int DEPTH = 64,
    parameter int CW = 7
) (
    input  logic          is_ft,
    input  logic          held,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] empty_ofs,
    input  logic [CW-1:0] full_ofs,
    output logic          head_flag,
    output logic          room_flag,
    output logic          almost_empty,
    output logic          almost_full,
    output logic          half_full
);
    localparam int XW = CW + 1;

    logic [XW-1:0] total;
    logic [XW-1:0] cap;
    logic [XW-1:0] hf_thr;
    logic [XW-1:0] af_sum;

    always_comb begin
        total  = {1'b0, cnt} + XW'(held);
        cap    = XW'(DEPTH) + XW'(is_ft);
        hf_thr = XW'(DEPTH / 2 + 1) + XW'(is_ft);
        af_sum = total + {1'b0, full_ofs};
    end

    assign head_flag    = is_ft ? held : (cnt == '0);
    assign room_flag    = is_ft ? (cnt < CW'(DEPTH)) : (cnt == CW'(DEPTH));
    assign almost_empty = total <= {1'b0, empty_ofs};
    assign almost_full  = af_sum >= cap;
    assign half_full    = total >= hf_thr;
endmodule

// File: rtl/fifo_lvl_top.sv
module fifo_lvl_top
    import fifo_lvl_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW = 9,
    parameter int DEF_EMPTY_OFS = 4,
    parameter int DEF_FULL_OFS = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          ft_mode,
    input  logic          wen,
    input  logic          ren,
    input  logic          rt,
    input  logic [DW-1:0] din,
    input  logic          ofs_wr,
    input  logic [CW-1:0] ofs_empty_in,
    input  logic [CW-1:0] ofs_full_in,
    output logic [DW-1:0] dout,
    output logic          head_flag,
    output logic          room_flag,
    output logic          almost_empty,
    output logic          almost_full,
    output logic          half_full
);
    rd_state_t     state_q, state_d;
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q;
    logic          wrapped_q;
    logic [DW-1:0] rdata;
    logic [CW-1:0] empty_ofs, full_ofs;
    logic          is_ft, held, wr_ok, pop, has_word, rewind;

    assign is_ft    = (state_q != S_STD);
    assign held     = (state_q == S_FT_HELD);
    assign has_word = (cnt_q != '0);
    assign rewind   = prst || rt;
    assign wr_ok    = wen && (cnt_q < CW'(DEPTH)) && !rewind;
    assign pop      = !rewind && has_word && (is_ft ? (!held || ren) : ren);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_STD:     state_d = S_STD;
            S_FT_DRY:  state_d = has_word ? S_FT_HELD : S_FT_DRY;
            S_FT_HELD: state_d = (ren && !has_word) ? S_FT_DRY : S_FT_HELD;
            default:   state_d = S_STD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (mrst)        state_q <= ft_mode ? S_FT_DRY : S_STD;
        else if (rewind) state_q <= is_ft ? S_FT_DRY : S_STD;
        else             state_q <= state_d;
    end

    // pointers, count and output register
    always_ff @(posedge clk) begin
        if (mrst || prst) begin
            wptr_q    <= '0;
            rptr_q    <= '0;
            cnt_q     <= '0;
            wrapped_q <= 1'b0;
            dout      <= '0;
        end else if (rt) begin
            rptr_q <= '0;
            cnt_q  <= wrapped_q ? CW'(DEPTH) : {1'b0, wptr_q};
        end else begin
            if (wr_ok) begin
                wptr_q <= wptr_q + 1'b1;
                if (wptr_q == '1) wrapped_q <= 1'b1;
            end
            if (pop) begin
                rptr_q <= rptr_q + 1'b1;
                dout   <= rdata;
            end
            cnt_q <= cnt_q + CW'(wr_ok) - CW'(pop);
        end
    end

    fifo_lvl_store #(.DW(DW), .AW(AW)) u_store (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (wptr_q),
        .wdata (din),
        .raddr (rptr_q),
        .rdata (rdata)
    );

    fifo_lvl_ofs #(
        .CW(CW), .DEF_EMPTY_OFS(DEF_EMPTY_OFS), .DEF_FULL_OFS(DEF_FULL_OFS)
    ) u_ofs (
        .clk       (clk),
        .mrst      (mrst),
        .ld        (ofs_wr),
        .empty_in  (ofs_empty_in),
        .full_in   (ofs_full_in),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

    fifo_lvl_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
        .is_ft        (is_ft),
        .held         (held),
        .cnt          (cnt_q),
        .empty_ofs    (empty_ofs),
        .full_ofs     (full_ofs),
        .head_flag    (head_flag),
        .room_flag    (room_flag),
        .almost_empty (almost_empty),
        .almost_full  (almost_full),
        .half_full    (half_full)
    );
endmodule

// File: rtl/fifo_lvl_chk.sv
module fifo_lvl_chk #(
    parameter int DW = 9
) (
    input logic          clk,
    input logic          mrst,
    input logic          prst,
    input logic          rt,
    input logic          wen,
    input logic          ren,
    input logic          ofs_wr,
    input logic          is_ft,
    input logic          head_flag,
    input logic          room_flag,
    input logic          almost_empty,
    input logic          almost_full,
    input logic          half_full,
    input logic [DW-1:0] dout
);
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (mrst)
        (!is_ft && room_flag && wen && !ren && !rt && !prst) |=> room_flag); // R1

    AST_FULL_IS_ALMOST: assert property (@(posedge clk) disable iff (mrst)
        (!is_ft && room_flag) |-> almost_full); // R2

    AST_HEAD_KEPT: assert property (@(posedge clk) disable iff (mrst)
        (is_ft && head_flag && !ren && !rt && !prst) |=> (head_flag && $stable(dout))); // R5

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (mrst)
        (!is_ft && head_flag && ren && !prst) |=> $stable(dout)); // R6

    AST_RW_STEADY: assert property (@(posedge clk) disable iff (mrst)
        (!is_ft && !head_flag && !room_flag && wen && ren && !rt && !prst && !ofs_wr)
        |=> $stable({head_flag, room_flag, almost_empty, almost_full, half_full})); // R7

    AST_MODE_FIXED: assert property (@(posedge clk) disable iff (mrst)
        !mrst |=> $stable(is_ft)); // R8
endmodule

bind fifo_lvl_top fifo_lvl_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .mrst         (mrst),
    .prst         (prst),
    .rt           (rt),
    .wen          (wen),
    .ren          (ren),
    .ofs_wr       (ofs_wr),
    .is_ft        (is_ft),
    .head_flag    (head_flag),
    .room_flag    (room_flag),
    .almost_empty (almost_empty),
    .almost_full  (almost_full),
    .half_full    (half_full),
    .dout         (dout)
);

// File: tb/sim_fifo_lvl_top.sv
`timescale 1ns/1ps
module sim_fifo_lvl_top;
    localparam int D  = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          mrst = 1'b1, prst = 1'b0, ft_mode = 1'b0;
    logic          wen = 1'b0, ren = 1'b0, rt = 1'b0, ofs_wr = 1'b0;
    logic [8:0]    din = '0;
    logic [CW-1:0] ofs_e = '0, ofs_f = '0;
    logic [8:0]    dout;
    logic          head_flag, room_flag, almost_empty, almost_full, half_full;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fifo_lvl_top #(.DEPTH(D), .DW(9), .DEF_EMPTY_OFS(2), .DEF_FULL_OFS(2)) u0 (
        .clk(clk), .mrst(mrst), .prst(prst), .ft_mode(ft_mode),
        .wen(wen), .ren(ren), .rt(rt), .din(din),
        .ofs_wr(ofs_wr), .ofs_empty_in(ofs_e), .ofs_full_in(ofs_f),
        .dout(dout), .head_flag(head_flag), .room_flag(room_flag),
        .almost_empty(almost_empty), .almost_full(almost_full), .half_full(half_full)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_mrst(input bit ft);
        mrst = 1'b1; ft_mode = ft;
        tick(); tick();
        mrst = 1'b0;
    endtask

    task automatic wr1(input int d);
        wen = 1'b1; din = 9'(d);
        tick();
        wen = 1'b0;
    endtask

    task automatic rd1();
        ren = 1'b1;
        tick();
        ren = 1'b0;
    endtask

    // standard-mode flags for count c, empty offset n, full offset m
    task automatic std_flags(input int c, input int n, input int m);
        chk("R6 empty", head_flag, c == 0);
        chk("R1 full", room_flag, c == D);
        chk("R2 almost_full", almost_full, c >= D - m);
        chk("R3 half_full", half_full, c >= D / 2 + 1);
        chk("R4 almost_empty", almost_empty, c <= n);
    endtask

    // fall-through flags for total t (default offsets)
    task automatic ft_flags(input int t);
        chk("R2 almost_full ft", almost_full, t >= D + 1 - 2);
        chk("R3 half_full ft", half_full, t >= D / 2 + 2);
        chk("R4 almost_empty ft", almost_empty, t <= 2);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // ---- standard mode: reset state (R11)
        do_mrst(1'b0);
        chk("R11 dout after reset", dout, 0);
        std_flags(0, 2, 2);

        // ---- fill sweep (R1 R2 R3 R4)
        for (int k = 0; k < D; k++) begin
            wr1(k * 3 + 1);
            std_flags(k + 1, 2, 2);
        end
        wr1(9'h1AA);                      // dropped (R1)
        std_flags(D, 2, 2);

        // ---- drain sweep (R6, R1 order intact)
        for (int i = 0; i < D; i++) begin
            rd1();
            chk("R6 read data", dout, i * 3 + 1);
            std_flags(D - 1 - i, 2, 2);
        end
        rd1();                            // read while empty
        chk("R6 empty read keeps dout", dout, (D - 1) * 3 + 1);
        chk("R6 still empty", head_flag, 1);

        // ---- simultaneous read and write (R7)
        for (int k = 0; k < 3; k++) wr1(100 + k);
        for (int j = 0; j < 5; j++) begin
            wen = 1'b1; ren = 1'b1; din = 9'(103 + j);
            tick();
            wen = 1'b0; ren = 1'b0;
            chk("R7 rw data", dout, 100 + j);
            std_flags(3, 2, 2);
        end

        // ---- retransmit in standard mode (R9)
        do_mrst(1'b0);
        for (int k = 0; k < 5; k++) wr1(200 + k);
        rd1(); rd1();
        chk("R9 pre-rt data", dout, 201);
        rt = 1'b1; tick(); rt = 1'b0;
        chk("R9 count after rt", half_full, 1);
        for (int k = 0; k < 5; k++) begin
            rd1();
            chk("R9 replay data", dout, 200 + k);
        end
        chk("R9 empty after replay", head_flag, 1);

        // ---- offsets and partial reset (R10 R11)
        ofs_wr = 1'b1; ofs_e = 4'd4; ofs_f = 4'd1;
        wr1(7);
        ofs_wr = 1'b0;
        prst = 1'b1; tick(); prst = 1'b0;
        chk("R10 empty after prst", head_flag, 1);
        chk("R10 dout cleared", dout, 0);
        for (int k = 0; k < D; k++) begin
            wr1(k);
            std_flags(k + 1, 4, 1);
        end
        do_mrst(1'b0);
        for (int k = 0; k < 3; k++) wr1(k);
        chk("R11 default n restored", almost_empty, 0);
        std_flags(3, 2, 2);

        // ---- fall-through: reset state and empty read (R5 R11)
        do_mrst(1'b1);
        chk("R5 or low after reset", head_flag, 0);
        chk("R5 ir high after reset", room_flag, 1);
        ft_flags(0);
        rd1();
        chk("R5 read when not ready", head_flag, 0);

        // ---- fall-through fill sweep (R5 R2 R3 R4)
        for (int k = 1; k <= D + 1; k++) begin
            wr1(50 + (k - 1) * 7);
            chk("R5 output ready", head_flag, k >= 2);
            chk("R5 input ready", room_flag, k < D + 1);
            ft_flags(k);
        end
        wr1(400);                         // dropped
        chk("R5 ir low when full", room_flag, 0);
        ft_flags(D + 1);
        for (int i = 0; i <= D; i++) begin
            chk("R5 head ready", head_flag, 1);
            chk("R5 head data", dout, 50 + i * 7);
            rd1();
            ft_flags(D - i);
        end
        chk("R5 drained", head_flag, 0);

        // ---- mode fixed (R8) and fall-through retransmit (R9)
        ft_mode = 1'b0;
        prst = 1'b1; tick(); prst = 1'b0;
        for (int k = 0; k < 4; k++) wr1(300 + k);
        tick();
        chk("R8 still fall-through", head_flag, 1);
        chk("R8 head without read", dout, 300);
        rd1(); rd1();
        chk("R9 ft pre-rt", dout, 302);
        rt = 1'b1; tick(); rt = 1'b0;
        tick();
        chk("R9 ft replay ready", head_flag, 1);
        chk("R9 ft replay data", dout, 300);
        ft_flags(4);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule